// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets on-chip logic read and write an external asynchronous static RAM of 8192 bytes. The logic uses a synchronous request port. The memory has a 13-bit address and one shared bidirectional 8-bit data bus. It has two chip selects, one active-low and one active-high, plus an active-low write strobe and an active-low output enable. The controller drives a memory write by overlapping all three write-side enables, and the write ends when the strobe rises. It sequences each access in whole clock cycles so that address setup, strobe width, data hold and read access time all meet the memory's minimums. The phase lengths are parameters, found by rounding the nanosecond figures up to clock periods. Every phase parameter must be at least 1.

A request is a valid/ready transfer carrying a write flag, an address and write data. The transfer completes on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle. A requester that sees `req_ready` low must hold `req_valid` and every request field unchanged until the transfer completes. Read results come back as a single-cycle `rsp_valid` pulse with `rsp_rdata`. The response has no back-pressure, so the requester must take the result in that cycle. Only one access is in flight at a time.

The controller never drives the data bus while the memory's output enable is low. Output enable stays high for the whole of every write. After each read, both chip selects stay inactive for a turnaround gap before any further access.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_cs_n` is 1, `mem_cs` is 0, `mem_we_n` is 1 and `mem_oe_n` is 1.
- R2: A request transfers only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from that edge until the access has finished, and a request held under back-pressure is taken once `req_ready` returns.
- R3: After a write of value D to address A, a later read of A returns D. Reads of addresses never written return the memory's existing contents.
- R4: During each write, `mem_we_n` is low for exactly WE_CYC consecutive cycles. It is low only while `mem_cs_n`=0 and `mem_cs`=1.
- R5: While the chip is selected, `mem_addr` does not change. `mem_we_n` falls no earlier than SETUP_CYC cycles after chip select is asserted. Chip select stays asserted for at least the cycle after `mem_we_n` rises.
- R6: Throughout the strobe-low window of a write, `mem_dq` carries the write data of that request and holds steady.
- R7: `mem_oe_n` and `mem_we_n` are never both low. The controller drives `mem_dq` only while `mem_oe_n` is high.
- R8: A read holds `mem_oe_n` low for exactly RD_CYC cycles. `rsp_valid` is high for one cycle, starting on the edge where `mem_oe_n` rises, and carries the byte the memory drove just before that edge. `rsp_valid` is never high at any other time.
- R9: After a read, the chip stays deselected for at least TURN_CYC cycles before the next access starts.
- R10: Whenever `req_ready` is high, the chip is deselected (`mem_cs_n`=1, `mem_cs`=0).
- R11: A write keeps `req_ready` low for SETUP_CYC+WE_CYC+HOLD_CYC cycles after acceptance. A read keeps it low for RD_CYC+TURN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read-result strobe |
| rsp_rdata | output | 8 | Read result |
| mem_addr | output | 13 | Memory address pins |
| mem_dq | inout | 8 | Shared memory data bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |

## Verification
The hardest case to reach is a write that follows a read with no spare cycle between them. This is the only point where the memory's output drivers and the controller's data drivers could overlap, and it is also where the turnaround gap must hold. To reach it, the bench presents the next request while the current access is still busy, so it waits under back-pressure and is accepted on the first idle edge. A seeded random mix of reads and writes, at the first and last addresses and at random addresses, produces read-to-write, write-to-read and same-address pairs back to back. Occasional idle gaps are added so that spaced accesses are covered too.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT,
    ST_RTURN
  } st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] bus,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= bus;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 3,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 4,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int MAXC = max_of(max_of(max_of(SETUP_CYC, WE_CYC), max_of(HOLD_CYC, RD_CYC)), TURN_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  st_e st, st_nxt;
  logic          ld, zero, cap;
  logic [CW-1:0] ld_val;
  logic          accept;

  logic              sel_q, we_q, oe_q, drv_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(zero)
  );

  always_comb begin
    st_nxt = st;
    ld     = 1'b0;
    ld_val = '0;
    cap    = 1'b0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        ld = 1'b1;
        if (req_write) begin
          st_nxt = ST_WSETUP;
          ld_val = CW'(SETUP_CYC - 1);
        end else begin
          st_nxt = ST_RWAIT;
          ld_val = CW'(RD_CYC - 1);
        end
      end
      ST_WSETUP: if (zero) begin
        st_nxt = ST_WPULSE; ld = 1'b1; ld_val = CW'(WE_CYC - 1);
      end
      ST_WPULSE: if (zero) begin
        st_nxt = ST_WHOLD; ld = 1'b1; ld_val = CW'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (zero) st_nxt = ST_IDLE;
      ST_RWAIT: if (zero) begin
        st_nxt = ST_RTURN; ld = 1'b1; ld_val = CW'(TURN_CYC - 1); cap = 1'b1;
      end
      ST_RTURN: if (zero) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      drv_en  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st     <= st_nxt;
      sel_q  <= (st_nxt == ST_WSETUP) || (st_nxt == ST_WPULSE) ||
                (st_nxt == ST_WHOLD)  || (st_nxt == ST_RWAIT);
      we_q   <= (st_nxt == ST_WPULSE);
      oe_q   <= (st_nxt == ST_RWAIT);
      drv_en <= (st_nxt == ST_WSETUP) || (st_nxt == ST_WPULSE) || (st_nxt == ST_WHOLD);
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = !sel_q;
  assign mem_cs   = sel_q;
  assign mem_we_n = !we_q;
  assign mem_oe_n = !oe_q;
  assign mem_dq   = drv_en ? wdata_q : 'z;

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(cap), .bus(mem_dq),
    .rvalid(rsp_valid), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              drv_en,
  input logic [DATA_W-1:0] drv_data
);
  // R4
  we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> mem_oe_n);
  // R7
  oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);
  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R6
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(drv_data));
  // R8
  rsp_at_oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_oe_n));
  // R8
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .drv_en(drv_en), .drv_data(wdata_q)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int SETUP = 1, WEC = 3, HOLD = 1, RDC = 4, TURN = 1;
  localparam int WR_LAT = SETUP + WEC + HOLD;
  localparam int RD_LAT = RDC + TURN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] mem_addr;
  wire  [7:0]  mem_dq;
  logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n;

  always #2 clk = ~clk;

  sram_ctrl #(.SETUP_CYC(SETUP), .WE_CYC(WEC), .HOLD_CYC(HOLD),
              .RD_CYC(RDC), .TURN_CYC(TURN)) i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [7:0] pattern(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] model_mem [int];
  int wr_cnt = 0;
  logic [7:0] m_dout;
  wire msel   = !mem_cs_n && mem_cs;
  wire m_drv  = msel && !mem_oe_n && mem_we_n;
  wire wr_act = msel && !mem_we_n;

  always @(mem_addr, m_drv, wr_cnt) begin
    if (model_mem.exists(int'(mem_addr))) m_dout = model_mem[int'(mem_addr)];
    else m_dout = pattern(int'(mem_addr));
  end
  assign mem_dq = m_drv ? m_dout : 'z;

  always @(negedge wr_act) begin
    if (rst_n === 1'b1) begin
      model_mem[int'(mem_addr)] = mem_dq;
      wr_cnt++;
    end
  end

  // ---------------- golden ----------------
  logic [7:0] gold [int];
  function automatic logic [7:0] gold_rd(input int a);
    if (gold.exists(a)) return gold[a];
    return pattern(a);
  endfunction

  logic [7:0] fl_wdata = '0, fl_exp = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- port monitor ----------------
  int we_run = 0, oe_run = 0, sel_run = 0, desel_run = 0;
  bit after_read = 0, prev_sel = 0;
  logic [12:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!mem_we_n) begin
        if (we_run == 0) chk(sel_run >= SETUP, "R5", "strobe setup", sel_run, SETUP);
        we_run++;
        chk(msel, "R4", "strobe outside select", 0, 1);
        chk(mem_dq === fl_wdata, "R6", "write data on bus", int'(mem_dq), int'(fl_wdata));
        chk(mem_oe_n, "R7", "oe low during write", 0, 1);
      end else if (we_run > 0) begin
        chk(we_run == WEC, "R4", "strobe width", we_run, WEC);
        chk(msel, "R5", "select hold after strobe", 0, 1);
        we_run = 0;
      end
      if (!mem_oe_n) begin
        oe_run++;
        chk(mem_we_n, "R7", "we low during read", 0, 1);
        chk(!rsp_valid, "R8", "early response", 1, 0);
      end else if (oe_run > 0) begin
        chk(oe_run == RDC, "R8", "oe width", oe_run, RDC);
        chk(rsp_valid, "R8", "response at oe release", 0, 1);
        chk(rsp_rdata == fl_exp, "R3", "read data", int'(rsp_rdata), int'(fl_exp));
        oe_run = 0;
        after_read = 1;
      end else if (rsp_valid) begin
        chk(0, "R8", "stray response", 1, 0);
      end
      if (msel) begin
        if (prev_sel) chk(mem_addr == prev_addr, "R5", "address moved", int'(mem_addr), int'(prev_addr));
        else begin
          if (after_read) chk(desel_run >= TURN, "R9", "turnaround gap", desel_run, TURN);
          after_read = 0;
        end
        sel_run++;
        desel_run = 0;
      end else begin
        sel_run = 0;
        desel_run++;
      end
      if (req_ready) chk(!msel, "R10", "selected while idle", 1, 0);
      prev_sel  = msel;
      prev_addr = mem_addr;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d,
                       input int prev_lat);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    n = 0;
    while (!req_ready) begin
      n++;
      @(negedge clk);
    end
    if (prev_lat >= 0)
      chk(n == prev_lat, "R11", "busy cycles", n, prev_lat);
    @(posedge clk);
    if (w) begin
      fl_wdata = d;
      gold[int'(a)] = d;
    end else begin
      fl_exp = gold_rd(int'(a));
    end
  endtask

  task automatic go_idle(input int k);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (k) @(negedge clk);
  endtask

  // R2: ready drops after acceptance and returns
  task automatic check_busy();
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready after accept", int'(req_ready), 0);
    repeat (8) @(negedge clk);
    chk(req_ready, "R2", "ready returns", int'(req_ready), 1);
  endtask

  initial begin
    int lat;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1 && rsp_valid == 0, "R1", "handshake reset", int'({req_ready, rsp_valid}), 2);
    chk(mem_cs_n == 1 && mem_cs == 0, "R1", "select reset", int'({mem_cs_n, mem_cs}), 2);
    chk(mem_we_n == 1 && mem_oe_n == 1, "R1", "strobe reset", int'({mem_we_n, mem_oe_n}), 3);
    rst_n = 1'b1;
    go_idle(2);

    // directed: edges of the address space, untouched read, back to back
    issue(0, 13'h0042, 8'h00, -1);         // R3 unwritten location
    issue(1, 13'h0000, 8'hA5, RD_LAT);      // read -> write turnaround (R9)
    issue(1, 13'h1FFF, 8'h5A, WR_LAT);
    issue(0, 13'h0000, 8'h00, WR_LAT);
    issue(0, 13'h1FFF, 8'h00, RD_LAT);
    issue(1, 13'h1FFF, 8'hFF, RD_LAT);
    issue(0, 13'h1FFF, 8'h00, WR_LAT);      // write then read same address
    check_busy();
    go_idle(3);

    // random mix with back-pressure and idle gaps
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      bit w;
      logic [12:0] a;
      w = ($urandom % 2) == 1;
      a = (($urandom % 4) == 0) ? 13'($urandom % 8) : 13'($urandom);
      issue(w, a, 8'($urandom), lat);
      lat = w ? WR_LAT : RD_LAT;
      if (($urandom % 10) == 0) begin
        go_idle(1 + ($urandom % 3));
        lat = -1;
      end
    end
    go_idle(12);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule